// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block is the status register of an asynchronous serial port. It keeps five flags that the serial shift logic sets and that software can only clear: transmit buffer empty, receive buffer full, overrun, framing error and parity error. It also keeps two flags that software can only read: transmit finished and received multiprocessor bit. One further bit, the multiprocessor-bit transfer control, is plain read/write.

A set flag can be cleared by software only in two steps. Software first reads the register while that flag is 1, which arms the flag. A later write that carries 0 in the flag's position then clears it. A DMA controller also clears flags through its data accesses. When it writes the transmit data register, the transmit-empty flag clears. When it reads the receive data register, the receive-full flag clears.

The block also holds the receive data register. A correctly received frame is copied into it only while the receive-full flag is 0. A frame that completes while that flag is still 1 raises the overrun flag, and the new byte is dropped.

Top module: `serial_status_reg`

## Requirements
- R1: After reset, and on any cycle with standby_i high, the status reads 0x84: bit 7 (transmit empty) and bit 2 (transmit end) are 1, and all other bits are 0. The receive data register reads 0.
- R2: A bus write of 1 to bit 7 (transmit empty), bit 6 (receive full), bit 5 (overrun), bit 4 (framing error) or bit 3 (parity error) never sets that bit. Bit 0 (multiprocessor-bit transfer control) takes the written value on every write.
- R3: A write of 0 to a clearable bit clears it only if a status read happened while that bit was 1, after the previous status write. Every status write consumes all arms, so a second write of 0 without a new read has no effect.
- R4: Bit 2 (transmit end) and bit 1 (multiprocessor bit) are not changed by bus writes.
- R5: Transmit empty is set by a tx_load_i pulse and held at 1 while tx_en_i is 0. It is cleared by the armed write of 0 or by dma_tdr_wr_i.
- R6: A rx_done_i with no error, arriving while receive full is 0, loads rx_data_i into the receive data register and sets receive full. Receive full is cleared by the armed write of 0 or by dma_rdr_rd_i.
- R7: A rx_done_i with rx_fer_i or rx_par_i set raises the matching error flag. It leaves the receive data register and receive full unchanged.
- R8: A rx_done_i while receive full is 1 sets overrun and keeps the old receive data.
- R9: When a set event and a clear (software or DMA) reach a flag in the same cycle, the flag is 1 afterwards.
- R10: Transmit end is set by tx_end_i and cleared by tx_load_i. The multiprocessor bit takes rx_mpb_i when a frame is loaded into the receive data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| standby_i | input | 1 | Standby entry, reinitialises the register |
| rd_i | input | 1 | Status read strobe (arms set flags) |
| wr_i | input | 1 | Status write strobe |
| wdata_i | input | DATA_W | Status write data |
| rdata_o | output | DATA_W | Status register value |
| tx_en_i | input | 1 | Transmit enable control level |
| tx_load_i | input | 1 | Transmit buffer moved into the shifter |
| tx_end_i | input | 1 | Transmit shifter finished with no byte pending |
| rx_done_i | input | 1 | Receive frame completed |
| rx_fer_i | input | 1 | Framing error on the completed frame |
| rx_par_i | input | 1 | Parity error on the completed frame |
| rx_mpb_i | input | 1 | Multiprocessor bit of the completed frame |
| rx_data_i | input | DATA_W | Data of the completed frame |
| dma_tdr_wr_i | input | 1 | DMA write to the transmit data register |
| dma_rdr_rd_i | input | 1 | DMA read of the receive data register |
| rdr_o | output | DATA_W | Receive data register |

## Verification
The bench builds the block with its default DATA_W of 8. At that width all 32 subsets of the five clearable flags can be armed and cleared in a single sweep. Each subset is checked for a correct partial clear and for a second, unarmed write that leaves the flags unchanged. The 8-bit data width also lets each overrun and error frame carry a byte distinct from the stored one, so preserved receive data is visible at rdr_o.

// File: rtl/serial_status_pkg.sv
package serial_status_pkg;
  localparam int unsigned NUM_CLR  = 5;
  localparam int unsigned IDX_PER  = 0;
  localparam int unsigned IDX_FER  = 1;
  localparam int unsigned IDX_OVR  = 2;
  localparam int unsigned IDX_RXF  = 3;
  localparam int unsigned IDX_TXE  = 4;
  localparam int unsigned CLR_LSB  = 3;  // clearable flags live in bits 7..3
  localparam int unsigned BIT_TEND = 2;
  localparam int unsigned BIT_MPB  = 1;
  localparam int unsigned BIT_MPBT = 0;
  localparam logic [NUM_CLR-1:0] CLR_RST = 5'b10000;
endpackage

// File: rtl/status_flag_cell.sv
module status_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic standby_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  input  logic set_i,
  input  logic hw_clr_i,
  output logic flag_o
);
  logic flag_q, arm_q, sw_clr;

  assign sw_clr = wr_i & ~wbit_i & arm_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else if (standby_i) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)                   flag_q <= 1'b1;  // set wins
      else if (sw_clr || hw_clr_i) flag_q <= 1'b0;
      // write consumes old arm; a read in the same cycle re-arms
      if (rd_i)      arm_q <= flag_q;
      else if (wr_i) arm_q <= 1'b0;
    end
  end

  a_r3_no_clear_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !arm_q && !hw_clr_i && !standby_i) |=> flag_q);
  a_r2_write_never_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !set_i && !standby_i) |=> !flag_q);
  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !standby_i) |=> flag_q);
endmodule

// File: rtl/status_rx_path.sv
module status_rx_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              rx_done_i,
  input  logic              rx_fer_i,
  input  logic              rx_par_i,
  input  logic              rx_mpb_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rxf_i,
  output logic              set_rxf_o,
  output logic              set_ovr_o,
  output logic              set_fer_o,
  output logic              set_per_o,
  output logic [DATA_W-1:0] rdr_o,
  output logic              mpb_o
);
  logic [DATA_W-1:0] rdr_q;
  logic              mpb_q, bad, load;

  assign bad       = rx_fer_i | rx_par_i;
  assign load      = rx_done_i & ~bad & ~rxf_i;
  assign set_rxf_o = load;
  assign set_ovr_o = rx_done_i & rxf_i;
  assign set_fer_o = rx_done_i & rx_fer_i;
  assign set_per_o = rx_done_i & rx_par_i;
  assign rdr_o     = rdr_q;
  assign mpb_o     = mpb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_q <= '0;
      mpb_q <= 1'b0;
    end else if (standby_i) begin
      rdr_q <= '0;
      mpb_q <= 1'b0;
    end else if (load) begin
      rdr_q <= rx_data_i;
      mpb_q <= rx_mpb_i;
    end
  end

  a_r8_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && rxf_i && !standby_i) |=> $stable(rdr_q));
  a_r7_error_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && bad && !standby_i) |=> $stable(rdr_q));
endmodule

// File: rtl/serial_status_reg.sv
module serial_status_reg
  import serial_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              standby_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tx_en_i,
  input  logic              tx_load_i,
  input  logic              tx_end_i,
  input  logic              rx_done_i,
  input  logic              rx_fer_i,
  input  logic              rx_par_i,
  input  logic              rx_mpb_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              dma_tdr_wr_i,
  input  logic              dma_rdr_rd_i,
  output logic [DATA_W-1:0] rdr_o
);
  logic [NUM_CLR-1:0] flags, set_v, hw_clr_v;
  logic tend_q, mpbt_q, mpb;
  logic set_rxf, set_ovr, set_fer, set_per;

  status_rx_path #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .standby_i,
    .rx_done_i, .rx_fer_i, .rx_par_i, .rx_mpb_i, .rx_data_i,
    .rxf_i     (flags[IDX_RXF]),
    .set_rxf_o (set_rxf),
    .set_ovr_o (set_ovr),
    .set_fer_o (set_fer),
    .set_per_o (set_per),
    .rdr_o,
    .mpb_o     (mpb)
  );

  always_comb begin
    set_v            = '0;
    set_v[IDX_TXE]   = tx_load_i | ~tx_en_i;
    set_v[IDX_RXF]   = set_rxf;
    set_v[IDX_OVR]   = set_ovr;
    set_v[IDX_FER]   = set_fer;
    set_v[IDX_PER]   = set_per;
    hw_clr_v          = '0;
    hw_clr_v[IDX_TXE] = dma_tdr_wr_i;
    hw_clr_v[IDX_RXF] = dma_rdr_rd_i;
  end

  for (genvar i = 0; i < NUM_CLR; i++) begin : g_flag
    status_flag_cell #(.RST_VAL(CLR_RST[i])) u_cell (
      .clk_i, .rst_ni, .standby_i, .rd_i, .wr_i,
      .wbit_i   (wdata_i[CLR_LSB+i]),
      .set_i    (set_v[i]),
      .hw_clr_i (hw_clr_v[i]),
      .flag_o   (flags[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tend_q <= 1'b1;
      mpbt_q <= 1'b0;
    end else if (standby_i) begin
      tend_q <= 1'b1;
      mpbt_q <= 1'b0;
    end else begin
      if (tx_end_i)       tend_q <= 1'b1;
      else if (tx_load_i) tend_q <= 1'b0;
      if (wr_i) mpbt_q <= wdata_i[BIT_MPBT];
    end
  end

  always_comb begin
    rdata_o                  = '0;
    rdata_o[CLR_LSB+:NUM_CLR] = flags;
    rdata_o[BIT_TEND]        = tend_q;
    rdata_o[BIT_MPB]         = mpb;
    rdata_o[BIT_MPBT]        = mpbt_q;
  end

  a_r4_tend_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_end_i && !tx_load_i && !standby_i) |=> $stable(tend_q));
  a_r4_mpb_read_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_done_i && !standby_i) |=> $stable(mpb));
  a_r5_txe_held_when_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_en_i && !standby_i) |=> flags[IDX_TXE]);
  a_r1_standby_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (flags == CLR_RST && tend_q && !mpbt_q));
endmodule

// File: tb/serial_status_reg_bench.sv
module serial_status_reg_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic standby = 0, rd = 0, wr = 0, tx_en = 1, tx_load = 0, tx_end = 0;
  logic rx_done = 0, rx_fer = 0, rx_par = 0, rx_mpb = 0, dma_tw = 0, dma_rr = 0;
  logic [W-1:0] wdata = '0, rx_data = '0, rdata, rdr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_status_reg #(.DATA_W(W)) u_serial_status_reg (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .rd_i(rd), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_en_i(tx_en), .tx_load_i(tx_load),
    .tx_end_i(tx_end), .rx_done_i(rx_done), .rx_fer_i(rx_fer), .rx_par_i(rx_par),
    .rx_mpb_i(rx_mpb), .rx_data_i(rx_data), .dma_tdr_wr_i(dma_tw),
    .dma_rdr_rd_i(dma_rr), .rdr_o(rdr)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic do_rd;
    rd = 1; tick(); rd = 0;
  endtask

  task automatic do_wr(input logic [W-1:0] v);
    wdata = v; wr = 1; tick(); wr = 0;
  endtask

  task automatic rx(input logic [W-1:0] d, input logic mpb, input logic fe, input logic pe);
    rx_data = d; rx_mpb = mpb; rx_fer = fe; rx_par = pe; rx_done = 1;
    tick(); rx_done = 0; rx_fer = 0; rx_par = 0;
  endtask

  task automatic pulse_load; tx_load = 1; tick(); tx_load = 0; endtask
  task automatic pulse_end;  tx_end = 1;  tick(); tx_end = 0;  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    chk("R1 reset status", rdata, 8'h84);
    chk("R1 reset rdr", rdr, 8'h00);

    // R3: unarmed write of 0
    do_wr(8'h00);
    chk("R3 unarmed write keeps tx empty", rdata, 8'h84);
    // R2: writes of 1 never set; bit0 r/w
    do_wr(8'hFF);
    chk("R2 write ones no set, mpbt=1", rdata, 8'h85);
    do_wr(8'h00);
    chk("R2 mpbt back to 0", rdata, 8'h84);

    // Sweep all 32 clear masks
    for (int m = 0; m < 32; m++) begin
      logic [W-1:0] mk, exp;
      do_rd(); do_wr(8'h00);
      pulse_load(); pulse_end();
      rx(8'hA5, 1'b1, 0, 0);
      rx(8'h3C, 1'b0, 0, 0);
      rx(8'h11, 1'b0, 1, 0);
      rx(8'h22, 1'b0, 0, 1);
      chk("R10/R8/R7 all flags set", rdata, 8'hFE);
      chk("R8 overrun keeps rdr", rdr, 8'hA5);
      if (m == 0) begin
        do_wr(8'h00);
        chk("R3 no clear without read", rdata, 8'hFE);
      end
      mk = W'(m) << 3;
      do_rd();
      do_wr((~mk & 8'hF8) | 8'h06);
      exp = 8'hFE & ~mk;
      chk("R3 armed partial clear", rdata, exp);
      chk("R4 tend/mpb survive write", rdata & 8'h06, 8'h06);
      do_wr(8'h00);
      chk("R3 arm consumed by write", rdata, exp);
    end

    // R4: read-only bits ignore write of 0
    do_rd(); do_wr(8'h00);
    chk("R4 tend and mpb unchanged", rdata, 8'h06);

    // R5: tx path
    pulse_load();
    chk("R5/R10 load sets empty, clears end", rdata, 8'h82);
    dma_tw = 1; tick(); dma_tw = 0;
    chk("R5 dma write clears empty", rdata, 8'h02);
    tx_en = 0; tick();
    chk("R5 disable sets empty", rdata, 8'h82);
    do_rd(); do_wr(8'h00);
    chk("R5 held while disabled", rdata, 8'h82);
    tx_en = 1; tick();
    do_rd(); do_wr(8'h00);
    chk("R5 software clears empty", rdata, 8'h02);

    // R6: receive and dma read
    rx(8'h5A, 1'b0, 0, 0);
    chk("R6 rdr loaded", rdr, 8'h5A);
    chk("R6/R10 rx full set, mpb 0", rdata, 8'h40);
    dma_rr = 1; tick(); dma_rr = 0;
    chk("R6 dma read clears full", rdata, 8'h00);
    // R7: error frame
    rx(8'h77, 1'b1, 1, 1);
    chk("R7 errors set, full clear", rdata, 8'h18);
    chk("R7 rdr unchanged", rdr, 8'h5A);

    // R9: set and clear together
    pulse_load();
    do_rd();
    wdata = 8'h00; wr = 1; tx_load = 1; tick(); wr = 0; tx_load = 0;
    chk("R9 set wins over sw clear (tx empty)", rdata & 8'h80, 8'h80);
    rx(8'h66, 1'b0, 0, 0);
    dma_rr = 1; rx_done = 1; rx_data = 8'h99; tick(); dma_rr = 0; rx_done = 0;
    chk("R9 overrun set with dma clear", rdata & 8'h60, 8'h20);
    chk("R8 rdr kept", rdr, 8'h66);

    // R1: standby
    standby = 1; tick(); standby = 0;
    chk("R1 standby status", rdata, 8'h84);
    chk("R1 standby rdr", rdr, 8'h00);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule